// File: doc/BRIEF.md
# Serial ADC Output and Offset Calibration Sequencer

This block is the digital back end of a 12-bit serial converter. It oversamples the host's chip-select and serial clock on a fast internal clock. It counts serial-clock falling edges inside each frame and drives the data pin, which has a separate output enable to model three-state. Every result is shifted out most significant bit first, behind two zero bits. The converter core is not modelled. It appears as two input ports: the raw conversion code and a freshly measured offset.

The block keeps a signed offset register that the host cannot read. The register is loaded only when a frame holds enough serial clocks: 16 in the first frame after power-up reset, 32 in any later frame. Each later result has the stored offset removed and is clamped to the code range before it is sent. The whole first frame after reset is a calibration frame, and the data pin stays low for all of it.

Top module: `adc_cal_seq`

## Requirements
- R1: While chip-select is high, the data output enable is low (high impedance).
- R2: On the chip-select falling edge the data output becomes enabled and is driven to 0.
- R3: On the 1st serial-clock falling edge of a frame the output is 0. Falling edges 2 through 13 present the 12 result bits, most significant bit first.
- R4: From the 14th serial-clock falling edge until chip-select rises, the output stays 0.
- R5: In the first frame after power-up reset, the output is 0 for the entire frame, whatever the raw code.
- R6: The first frame loads the offset register only if it reaches at least 16 falling edges. A shorter first frame leaves the register unchanged.
- R7: A later frame loads the offset register with the offset input value present at its 32nd falling edge. A frame with fewer than 32 falling edges leaves the register unchanged.
- R8: Power-up reset clears the offset register to zero.
- R9: The result is the raw code captured at the chip-select falling edge, minus the signed stored offset. Later changes to the raw input during the frame have no effect.
- R10: The corrected result saturates at 0x000 and 0xFFF instead of wrapping.
- R11: After the first frame ends, whatever its length, every later frame is a normal frame until the next power-up reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| cs_n | input | 1 | Active-low frame select, synchronous to clk |
| sclk | input | 1 | Serial clock, synchronous to clk; falling edges counted |
| raw_code | input | 12 | Uncorrected conversion code from the converter core |
| meas_ofs | input | 8 | Signed offset measured by the core during calibration |
| sdo_d | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial data drive enable (0 = high impedance) |

## Verification
The hardest case to reach is a committed offset that differs from zero. A nonzero offset appears only after a frame with 32 or more serial clocks, or after a first frame with 16 or more. A frame that ends one clock short must leave it untouched. The stimulus therefore chains frames: a long frame loads a value, a short frame proves it was loaded, a 31-clock frame proves no load happened, and repeated resets show the register cleared and the first-frame behaviour restored. Offsets of both signs combine with raw codes near 0x000 and 0xFFF to drive the clamp at both ends.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
   typedef struct packed {
      logic cs_fall;
      logic cs_rise;
      logic sclk_fall;
   } frm_evt_t;
endpackage

// File: rtl/frm_edge_det.sv
module frm_edge_det
   import adc_cal_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cs_n,
   input  logic     sclk,
   output frm_evt_t evt
);
   logic cs_q, sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         cs_q   <= cs_n;
         sclk_q <= sclk;
      end
   end

   always_comb begin
      evt.cs_fall   = cs_q & ~cs_n;
      evt.cs_rise   = ~cs_q & cs_n;
      evt.sclk_fall = sclk_q & ~sclk & ~cs_n & cs_q == 1'b0;
   end

   p_evt_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt.cs_fall, evt.cs_rise, evt.sclk_fall}));
endmodule

// File: rtl/frm_edge_cnt.sv
module frm_edge_cnt #(
   parameter int unsigned CNT_MAX = 33,
   localparam int unsigned CNT_W = $clog2(CNT_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             edge_hit,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

   always_comb begin
      cnt_nxt = cnt_q;
      if (frame_start)
         cnt_nxt = '0;
      else if (edge_hit && cnt_q != LIMIT)
         cnt_nxt = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == LIMIT && !frame_start) |=> cnt_q == LIMIT);
   p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> cnt_q == '0);
endmodule

// File: rtl/ofs_corr.sv
module ofs_corr #(
   parameter int unsigned CODE_W   = 12,
   parameter int unsigned OFS_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit,
   input  logic signed [OFS_W-1:0] meas_ofs,
   input  logic [CODE_W-1:0]       raw_code,
   output logic [CODE_W-1:0]       corr_code
);
   localparam int unsigned DIFF_W = CODE_W + 2;
   localparam logic signed [DIFF_W-1:0] TOP = DIFF_W'((1 << CODE_W) - 1);

   logic signed [OFS_W-1:0]  ofs_q;
   logic signed [DIFF_W-1:0] diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ofs_q <= '0;
      else if (commit) ofs_q <= meas_ofs;
   end

   assign diff = $signed({2'b00, raw_code}) - DIFF_W'(ofs_q);

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (diff < 0)        corr_code = '0;
            else if (diff > TOP) corr_code = '1;
            else                 corr_code = diff[CODE_W-1:0];
         end
      end else begin : g_wrap
         assign corr_code = diff[CODE_W-1:0];
      end
   endgenerate

   p_ofs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(ofs_q));
   p_ofs_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> ofs_q == $past(meas_ofs));
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
   parameter int unsigned CODE_W = 12,
   parameter int unsigned CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_end,
   input  logic              edge_hit,
   input  logic              mute,
   input  logic [CNT_W-1:0]  cnt_nxt,
   input  logic [CODE_W-1:0] code,
   output logic              sdo_d,
   output logic              sdo_oe
);
   localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(2);
   localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(CODE_W + 1);

   logic [CODE_W-1:0] shreg;
   logic              in_window;

   assign in_window = cnt_nxt >= FIRST_BIT && cnt_nxt <= LAST_BIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         sdo_d  <= 1'b0;
         sdo_oe <= 1'b0;
      end else if (frame_start) begin
         shreg  <= code;
         sdo_d  <= 1'b0;
         sdo_oe <= 1'b1;
      end else if (frame_end) begin
         sdo_d  <= 1'b0;
         sdo_oe <= 1'b0;
      end else if (edge_hit) begin
         if (in_window) begin
            sdo_d <= shreg[CODE_W-1] & ~mute;
            shreg <= {shreg[CODE_W-2:0], 1'b0};
         end else begin
            sdo_d <= 1'b0;
         end
      end
   end

   p_tail_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit && cnt_nxt > LAST_BIT) |=> !sdo_d);
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
   import adc_cal_pkg::*;
#(
   parameter int unsigned CODE_W        = 12,
   parameter int unsigned OFS_W         = 8,
   parameter int unsigned FIRST_CAL_CLK = 16,
   parameter int unsigned NORM_CAL_CLK  = 32,
   parameter bit          SATURATE      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic [CODE_W-1:0] raw_code,
   input  logic [OFS_W-1:0]  meas_ofs,
   output logic              sdo_d,
   output logic              sdo_oe
);
   localparam int unsigned CNT_MAX = NORM_CAL_CLK + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] FIRST_HIT = CNT_W'(FIRST_CAL_CLK);
   localparam logic [CNT_W-1:0] NORM_HIT  = CNT_W'(NORM_CAL_CLK);

   initial begin
      if (OFS_W >= CODE_W)
         $error("offset width must be narrower than the code width");
      if (FIRST_CAL_CLK < 1 || FIRST_CAL_CLK > NORM_CAL_CLK)
         $error("first-frame calibration count out of range");
      if (NORM_CAL_CLK <= CODE_W + 1)
         $error("normal calibration must end after the data bits");
   end

   frm_evt_t         evt;
   logic [CNT_W-1:0] cnt_nxt, cnt_q;
   logic [CODE_W-1:0] corr_code;
   logic             first_frame;
   logic             commit;

   frm_edge_det u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .sclk  (sclk),
      .evt   (evt)
   );

   frm_edge_cnt #(.CNT_MAX(CNT_MAX)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (evt.cs_fall),
      .edge_hit    (evt.sclk_fall),
      .cnt_nxt     (cnt_nxt),
      .cnt_q       (cnt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           first_frame <= 1'b1;
      else if (evt.cs_rise) first_frame <= 1'b0;
   end

   assign commit = evt.sclk_fall && cnt_q != cnt_nxt &&
                   (first_frame ? cnt_nxt == FIRST_HIT : cnt_nxt == NORM_HIT);

   ofs_corr #(.CODE_W(CODE_W), .OFS_W(OFS_W), .SATURATE(SATURATE)) u_ofs (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .meas_ofs  ($signed(meas_ofs)),
      .raw_code  (raw_code),
      .corr_code (corr_code)
   );

   ser_shift #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (evt.cs_fall),
      .frame_end   (evt.cs_rise),
      .edge_hit    (evt.sclk_fall),
      .mute        (first_frame),
      .cnt_nxt     (cnt_nxt),
      .code        (corr_code),
      .sdo_d       (sdo_d),
      .sdo_oe      (sdo_oe)
   );

   p_hiz_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !sdo_oe);
   p_fall_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |=> sdo_oe && !sdo_d);
   p_first_mute_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (first_frame && !cs_n) |=> !sdo_d);
   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !first_frame |=> !first_frame);
endmodule

// File: tb/adc_cal_seq_test.sv
module adc_cal_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b1;
   logic [11:0] raw_code = '0;
   logic [7:0]  meas_ofs = '0;
   logic        sdo_d, sdo_oe;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   adc_cal_seq uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
      .raw_code(raw_code), .meas_ofs(meas_ofs),
      .sdo_d(sdo_d), .sdo_oe(sdo_oe)
   );

   // {raw, offset input, clock count, expected code}
   localparam int NV = 11;
   localparam logic [39:0] VECS [NV] = '{
      {12'hABC, 8'h05, 8'd10, 12'h000},   // R5 R6 first frame short
      {12'h800, 8'h10, 8'd16, 12'h800},   // R11 R8 normal, no load
      {12'h123, 8'h05, 8'd32, 12'h123},   // R7 loads 5
      {12'h123, 8'h00, 8'd16, 12'h11E},   // R9
      {12'h003, 8'h00, 8'd16, 12'h000},   // R10 low clamp
      {12'hFFF, 8'hFD, 8'd33, 12'hFFA},   // R7 loads -3
      {12'hFFE, 8'h00, 8'd16, 12'hFFF},   // R10 high clamp
      {12'h400, 8'h14, 8'd31, 12'h403},   // R7 31 clocks, no load
      {12'h400, 8'h00, 8'd14, 12'h403},   // R7 confirms
      {12'h7FF, 8'h00, 8'd40, 12'h802},   // R7 loads 0
      {12'h7FF, 8'h00, 8'd14, 12'h7FF}    // R9
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic frame(input logic [11:0] raw, input logic [7:0] ofs,
                        input int nclk, input logic [11:0] exp, input string req);
      logic [11:0] word = '0;
      bit first_bad = 0, tail_bad = 0;
      raw_code = raw;
      meas_ofs = ofs;
      cs_n = 1'b0;
      tick(2);
      check(sdo_oe && !sdo_d, "R2", {sdo_oe, sdo_d}, 2);
      raw_code = ~raw;   // R9: must be ignored after capture
      for (int k = 1; k <= nclk; k++) begin
         sclk = 1'b0;
         tick(2);
         if (k == 1 && sdo_d) first_bad = 1;
         else if (k >= 2 && k <= 13) word[13-k] = sdo_d;
         else if (k >= 14 && sdo_d) tail_bad = 1;
         sclk = 1'b1;
         tick(2);
      end
      check(!first_bad, "R3", first_bad, 0);
      check(!tail_bad, "R4", tail_bad, 0);
      check(word == exp, req, word, exp);
      cs_n = 1'b1;
      tick(3);
      check(!sdo_oe, "R1", sdo_oe, 0);
      tick(4);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cs_n = 1'b1;
      sclk = 1'b1;
      tick(3);
      check(!sdo_oe && !sdo_d, "R1", {sdo_oe, sdo_d}, 0);
      rst_n = 1'b1;
      tick(3);
   endtask

   initial begin
      tick(1);
      do_reset();
      for (int i = 0; i < NV; i++)
         frame(VECS[i][39:28], VECS[i][27:20], int'(VECS[i][19:12]),
               VECS[i][11:0], "R9/R10 vector");
      // R6 R5: full first frame loads offset 7, output muted
      do_reset();
      frame(12'h555, 8'h07, 16, 12'h000, "R5");
      frame(12'h100, 8'h00, 14, 12'h0F9, "R6");
      // R8: reset clears offset; short first frame, then uncorrected result
      do_reset();
      frame(12'hFFF, 8'h30, 2, 12'h000, "R5");
      frame(12'h100, 8'h00, 14, 12'h100, "R8");
      // R11: second frame after reset is normal even with 16 clocks
      frame(12'h0AA, 8'h22, 16, 12'h0AA, "R11");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule